// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block keeps the single reservation that pairs a load-reserve with a later store-conditional on one processor. Each request carries an operation code, two base register values (the first with a flag saying it names register zero), and store data. The block forms the effective address and sends a word read or word write straight to memory in the same cycle. One cycle later it returns the loaded word or a 4-bit condition field that reports the store outcome.

A load-reserve arms the reservation and records its address. It replaces any reservation already held. A store-conditional writes memory only if the reservation is armed and its address matches. It disarms the reservation whether or not it succeeds. The reservation flag and address are outputs, so the surrounding pipeline can observe them.

Top module: `resv_tracker`

## Requirements
- R1: The effective address on `mem_addr` during a request equals `base_b` plus `base_a`. When `base_a_zero` is 1, `base_a` counts as the constant 0.
- R2: A load-reserve (`req_op` = 0) raises `mem_rd_en` in the request cycle. The next cycle `load_data` carries the word that memory returns, and `cr_wr_en` stays 0.
- R3: A load-reserve sets `resv_valid` to 1 and `resv_addr` to its effective address from the next cycle on. This replaces any earlier reservation.
- R4: A store-conditional (`req_op` = 1) leaves `resv_valid` at 0 from the next cycle on, whether it succeeds or fails.
- R5: A store-conditional succeeds when `resv_valid` is 1 and its effective address equals `resv_addr`. On success it raises `mem_wr_en` with `mem_wr_data` equal to `store_data` in the request cycle. The next cycle it raises `cr_wr_en` with `cr_field` = 4'b0010 (bit 1 is the equal flag; bits 3, 2 and 0 are zero).
- R6: A store-conditional that does not succeed raises no `mem_wr_en` and leaves memory unchanged. The next cycle it gives `cr_wr_en` = 1 with `cr_field` = 4'b0000.
- R7: Synchronous reset clears `resv_valid`, `resv_addr` and `done`.
- R8: `done` is high in exactly the cycles that follow a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = load-reserve, 1 = store-conditional |
| base_a | input | 32 | First base register value |
| base_a_zero | input | 1 | First base names register zero (use 0) |
| base_b | input | 32 | Second base register value |
| store_data | input | 32 | Word to store |
| mem_rd_en | output | 1 | Memory word read request |
| mem_wr_en | output | 1 | Memory word write request |
| mem_addr | output | 32 | Effective address |
| mem_wr_data | output | 32 | Memory write data |
| mem_rd_data | input | 32 | Word read, valid the cycle after `mem_rd_en` |
| done | output | 1 | Result valid |
| load_data | output | 32 | Loaded word for a load-reserve |
| cr_wr_en | output | 1 | Condition field update valid |
| cr_field | output | 4 | Condition field value |
| resv_valid | output | 1 | Reservation armed |
| resv_addr | output | 32 | Reserved address |

## Verification
The assertions assume that `req_op` is known whenever `req_valid` is high. They also assume that memory answers a read in the cycle right after the read request and applies a write at the edge that ends the request cycle. The bench memory is a synchronous array that behaves exactly that way. The bench drives only fully defined operation codes and operand values. It sweeps base values, the zero-register flag, matching and mismatching addresses, repeated stores and an overwritten reservation. It also drops reset while a reservation is held.

// File: rtl/resv_pkg.sv
package resv_pkg;

   typedef enum logic {
      OP_LOAD_RSV   = 1'b0,
      OP_STORE_COND = 1'b1
   } resv_op_e;

   localparam int CR_W     = 4;
   localparam int CR_LT    = 3;
   localparam int CR_GT    = 2;
   localparam int CR_EQ    = 1;
   localparam int CR_SO    = 0;
   localparam int WORD_W   = 32;

endpackage

// File: rtl/resv_ea_calc.sv
module resv_ea_calc #(
   parameter int ADDR_W         = 32,
   parameter bit HONOR_ZERO_REG = 1'b1
) (
   input  logic [ADDR_W-1:0] base_a,
   input  logic              base_a_zero,
   input  logic [ADDR_W-1:0] base_b,
   output logic [ADDR_W-1:0] eff_addr
);

   logic [ADDR_W-1:0] a_term;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("resv_ea_calc: ADDR_W must be at least 8");
      end

      if (HONOR_ZERO_REG) begin : g_zero_reg
         // register zero as an address base reads as a literal zero
         assign a_term = base_a_zero ? '0 : base_a;
      end else begin : g_plain
         logic unused_flag;
         assign unused_flag = base_a_zero;
         assign a_term = base_a;
      end
   endgenerate

   assign eff_addr = a_term + base_b;

endmodule

// File: rtl/resv_state.sv
module resv_state #(
   parameter int ADDR_W  = 32,
   parameter int CHUNK_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arm,
   input  logic              disarm,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              held,
   output logic [ADDR_W-1:0] held_addr,
   output logic              hit
);

   localparam int NCHUNK = ADDR_W / CHUNK_W;

   logic [NCHUNK-1:0] chunk_eq;

   generate
      if (ADDR_W % CHUNK_W != 0) begin : g_bad_chunk
         $error("resv_state: ADDR_W must be a multiple of CHUNK_W");
      end
      // split the comparator into narrow slices and AND them together
      for (genvar g = 0; g < NCHUNK; g++) begin : g_cmp
         assign chunk_eq[g] = (probe_addr[g*CHUNK_W +: CHUNK_W] ==
                               held_addr[g*CHUNK_W +: CHUNK_W]);
      end
   endgenerate

   assign hit = held & (&chunk_eq);

   always_ff @(posedge clk) begin
      if (rst) begin
         held      <= 1'b0;
         held_addr <= '0;
      end else if (arm) begin
         held      <= 1'b1;
         held_addr <= arm_addr;
      end else if (disarm) begin
         held      <= 1'b0;
      end
   end

endmodule

// File: rtl/resv_resp.sv
module resv_resp
   import resv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic              is_store,
   input  logic              stored,
   input  logic [DATA_W-1:0] rd_word,
   output logic              done,
   output logic [DATA_W-1:0] load_data,
   output logic              cr_wr_en,
   output logic [CR_W-1:0]   cr_field
);

   logic            was_load;
   logic            ok_q;
   logic [CR_W-1:0] cr_next;

   generate
      for (genvar i = 0; i < CR_W; i++) begin : g_cr
         if (i == CR_EQ) begin : g_eq
            assign cr_next[i] = ok_q;
         end else begin : g_zero
            assign cr_next[i] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         done     <= 1'b0;
         was_load <= 1'b0;
         cr_wr_en <= 1'b0;
         ok_q     <= 1'b0;
      end else begin
         done     <= fire;
         was_load <= fire & ~is_store;
         cr_wr_en <= fire & is_store;
         ok_q     <= fire & is_store & stored;
      end
   end

   assign cr_field  = cr_wr_en ? cr_next : '0;
   assign load_data = was_load ? rd_word : '0;

endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
   import resv_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_op,
   input  logic [ADDR_W-1:0] base_a,
   input  logic              base_a_zero,
   input  logic [ADDR_W-1:0] base_b,
   input  logic [DATA_W-1:0] store_data,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              done,
   output logic [DATA_W-1:0] load_data,
   output logic              cr_wr_en,
   output logic [3:0]        cr_field,
   output logic              resv_valid,
   output logic [ADDR_W-1:0] resv_addr
);

   generate
      if (DATA_W != WORD_W) begin : g_bad_data
         $error("resv_tracker: accesses are words, DATA_W must be 32");
      end
   endgenerate

   resv_op_e          op;
   logic              is_lr;
   logic              is_sc;
   logic              hit;
   logic [ADDR_W-1:0] ea;

   assign op    = resv_op_e'(req_op);
   assign is_lr = req_valid & (op == OP_LOAD_RSV);
   assign is_sc = req_valid & (op == OP_STORE_COND);

   resv_ea_calc #(.ADDR_W(ADDR_W), .HONOR_ZERO_REG(1'b1)) ea_i (
      .base_a      (base_a),
      .base_a_zero (base_a_zero),
      .base_b      (base_b),
      .eff_addr    (ea)
   );

   resv_state #(.ADDR_W(ADDR_W), .CHUNK_W(8)) state_i (
      .clk        (clk),
      .rst        (rst),
      .arm        (is_lr),
      .disarm     (is_sc),
      .arm_addr   (ea),
      .probe_addr (ea),
      .held       (resv_valid),
      .held_addr  (resv_addr),
      .hit        (hit)
   );

   assign mem_rd_en   = is_lr;
   assign mem_wr_en   = is_sc & hit;
   assign mem_addr    = ea;
   assign mem_wr_data = store_data;

   resv_resp #(.DATA_W(DATA_W)) resp_i (
      .clk       (clk),
      .rst       (rst),
      .fire      (req_valid),
      .is_store  (is_sc),
      .stored    (mem_wr_en),
      .rd_word   (mem_rd_data),
      .done      (done),
      .load_data (load_data),
      .cr_wr_en  (cr_wr_en),
      .cr_field  (cr_field)
   );

endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_op,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic              cr_wr_en,
   input logic [3:0]        cr_field,
   input logic              resv_valid,
   input logic [ADDR_W-1:0] resv_addr
);

   // R3: a load-reserve arms the reservation at its own address
   a_r3_lr_arms: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en |=> (resv_valid && resv_addr == $past(mem_addr)));

   // R4: every store-conditional leaves the reservation disarmed
   a_r4_sc_disarms: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_op) |=> !resv_valid);

   // R5: a write implies an armed, matching reservation
   a_r5_write_needs_match: assert property (@(posedge clk) disable iff (rst)
      mem_wr_en |-> (resv_valid && mem_addr == resv_addr));

   // R5: a successful store reports only the equal flag
   a_r5_success_cr: assert property (@(posedge clk) disable iff (rst)
      mem_wr_en |=> (cr_wr_en && cr_field == 4'b0010));

   // R6: a failed store reports an all-zero field
   a_r6_fail_cr: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_op && !mem_wr_en) |=> (cr_wr_en && cr_field == 4'b0000));

   // R2: read and write are never requested together
   a_r2_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_en && mem_wr_en));

   // R8: done follows each request by one cycle
   a_r8_done_after_req: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> done);
   a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !done);

   // R7: leaving reset, state is clear
   a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!resv_valid && !done && resv_addr == '0));

endmodule

bind resv_tracker resv_tracker_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .mem_rd_en  (mem_rd_en),
   .mem_wr_en  (mem_wr_en),
   .mem_addr   (mem_addr),
   .done       (done),
   .cr_wr_en   (cr_wr_en),
   .cr_field   (cr_field),
   .resv_valid (resv_valid),
   .resv_addr  (resv_addr)
);

// File: tb/resv_tracker_tb_top.sv
`timescale 1ns/1ps
module resv_tracker_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_op = 1'b0;
   logic [31:0] base_a = '0;
   logic        base_a_zero = 1'b0;
   logic [31:0] base_b = '0;
   logic [31:0] store_data = '0;
   logic        mem_rd_en, mem_wr_en;
   logic [31:0] mem_addr, mem_wr_data, mem_rd_data;
   logic        done, cr_wr_en, resv_valid;
   logic [31:0] load_data, resv_addr;
   logic [3:0]  cr_field;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [31:0] mem     [16];
   logic [31:0] ref_mem [16];
   logic        ref_v;
   logic [31:0] ref_a;

   always #2.5 clk = ~clk;

   resv_tracker dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .base_a(base_a), .base_a_zero(base_a_zero), .base_b(base_b),
      .store_data(store_data), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
      .done(done), .load_data(load_data), .cr_wr_en(cr_wr_en),
      .cr_field(cr_field), .resv_valid(resv_valid), .resv_addr(resv_addr)
   );

   // synchronous word memory: read data the cycle after the request
   always @(posedge clk) begin
      if (mem_wr_en) mem[mem_addr[5:2]] <= mem_wr_data;
      if (mem_rd_en) mem_rd_data <= mem[mem_addr[5:2]];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic do_req(input bit op, input logic [31:0] a, input bit z,
                         input logic [31:0] b, input logic [31:0] d);
      logic [31:0] ea_e;
      logic [31:0] exp_ld;
      bit          succ;
      ea_e = b + (z ? 32'd0 : a);
      succ = op && ref_v && (ea_e == ref_a);
      exp_ld = '0;
      req_valid = 1'b1; req_op = op; base_a = a; base_a_zero = z;
      base_b = b; store_data = d;
      #1;
      chk("R1 address", mem_addr, ea_e);
      chk("R2 read request", {31'd0, mem_rd_en}, {31'd0, !op});
      chk(succ ? "R5 write request" : "R6 no write", {31'd0, mem_wr_en}, {31'd0, succ});
      if (succ) chk("R5 write data", mem_wr_data, d);
      @(posedge clk);
      if (!op) begin
         exp_ld = ref_mem[ea_e[5:2]];
         ref_v = 1'b1;
         ref_a = ea_e;
      end else begin
         ref_v = 1'b0;
         if (succ) ref_mem[ea_e[5:2]] = d;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 done", {31'd0, done}, 32'd1);
      if (!op) begin
         chk("R2 load data", load_data, exp_ld);
         chk("R2 no cr update", {31'd0, cr_wr_en}, 32'd0);
         chk("R3 reserved addr", resv_addr, ref_a);
      end else begin
         chk("R5/R6 cr update", {31'd0, cr_wr_en}, 32'd1);
         chk(succ ? "R5 cr value" : "R6 cr value", {28'd0, cr_field},
             succ ? 32'h2 : 32'h0);
      end
      chk(op ? "R4 flag" : "R3 flag", {31'd0, resv_valid}, {31'd0, ref_v});
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i]     = 32'hA000_0000 + i;
         ref_mem[i] = 32'hA000_0000 + i;
      end
      ref_v = 1'b0;
      ref_a = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 reset flag", {31'd0, resv_valid}, 32'd0);
      chk("R7 reset addr", resv_addr, 32'd0);
      chk("R7 reset done", {31'd0, done}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R8 idle done", {31'd0, done}, 32'd0);

      // store with no reservation fails (R6)
      do_req(1'b1, 32'd4, 1'b0, 32'd0, 32'h1111_1111);

      // sweep bases, zero flag, matching and mismatching stores
      for (int ai = 0; ai < 4; ai++) begin
         for (int z = 0; z < 2; z++) begin
            for (int bi = 0; bi < 4; bi++) begin
               logic [31:0] a, b, d;
               a = (z != 0) ? (32'hDEAD_BEE0 + ai) : (ai * 4);
               b = bi * 8;
               d = 32'h5000_0000 + (ai << 8) + (z << 4) + bi;
               do_req(1'b0, a, z[0], b, 32'd0);
               if (((ai + bi) % 2) == 0)
                  do_req(1'b1, a, z[0], b, d);          // R5 match
               else
                  do_req(1'b1, a, z[0], b + 4, d);      // R6 mismatch
               do_req(1'b1, a, z[0], b, d ^ 32'hFFFF);  // R4 now disarmed
               do_req(1'b0, a, z[0], b, 32'd0);         // memory effect
               do_req(1'b1, 32'd0, 1'b1, 32'd60, d);    // disarm, likely miss
            end
         end
      end

      // R3 overwrite: second load-reserve replaces the first
      do_req(1'b0, 32'd8, 1'b0, 32'd0, 32'd0);
      do_req(1'b0, 32'd16, 1'b0, 32'd4, 32'd0);
      do_req(1'b1, 32'd8, 1'b0, 32'd0, 32'hCAFE_0001);
      do_req(1'b0, 32'd8, 1'b0, 32'd0, 32'd0);
      do_req(1'b0, 32'd16, 1'b0, 32'd4, 32'd0);
      do_req(1'b1, 32'd16, 1'b0, 32'd4, 32'hCAFE_0002);
      do_req(1'b0, 32'd0, 1'b1, 32'd20, 32'd0);

      @(negedge clk);
      chk("R8 no done when idle", {31'd0, done}, 32'd0);

      // R7 reset while a reservation is held
      do_req(1'b0, 32'd12, 1'b0, 32'd0, 32'd0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      ref_v = 1'b0;
      ref_a = '0;
      chk("R7 flag cleared", {31'd0, resv_valid}, 32'd0);
      chk("R7 addr cleared", resv_addr, 32'd0);
      do_req(1'b1, 32'd12, 1'b0, 32'd0, 32'hBAD0_0000);
      do_req(1'b0, 32'd12, 1'b0, 32'd0, 32'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule